// File: doc/BRIEF.md
# Next-PC Instruction Fetch Unit

This block holds the program counter of a single-cycle processor and works out the address of the next instruction. Each cycle the current PC goes out as the instruction-memory address. The instruction word that the memory returns goes straight back out of the block, unregistered, to the decoder.

On each rising clock edge the PC normally moves forward by one instruction word, which is 4 bytes. A PC-relative branch is taken only when control selects branch mode and the ALU zero flag is also high. The branch target is the incremented PC plus the 16-bit immediate, after that immediate has been sign-extended and turned into a byte offset by a shift left of two. All address arithmetic wraps modulo 2^32.

A parameter chooses how the target adder is built. In the chained form the offset is added to the incremented PC. In the parallel form the word step is first folded into the offset, and the result is added to the raw PC.

Top module: `fetch_next_pc`

## Requirements
- R1: When `rst` is high at a rising edge, the PC becomes 0 on that edge, whatever the branch inputs are.
- R2: `instr` equals `imem_rdata` in the same cycle, and `pc` is the address being fetched.
- R3: With `br_sel` = 0 the PC advances by 4 at each edge, whatever the immediate is.
- R4: With `br_sel` = 1 and `alu_zero` = 1 the next PC is PC + 4 + (sign-extended `imm` shifted left by 2). `imm` is a two's-complement count of words.
- R5: With `br_sel` = 1 and `alu_zero` = 0 the next PC is PC + 4.
- R6: A negative immediate moves the PC backwards. An immediate of -1 keeps the PC unchanged, and -32768 gives PC + 4 - 131072.
- R7: Address arithmetic wraps modulo 2^32. A branch below address 0 lands near 2^32, and an increment from 0xFFFFFFFC gives 0.
- R8: PC bits [1:0] are 0 in every cycle after reset.
- R9: `alu_zero` = 1 has no effect while `br_sel` = 0: the PC still advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| br_sel | input | 1 | Next-PC select: 0 sequential, 1 branch |
| alu_zero | input | 1 | ALU zero flag from the comparison |
| imm | input | 16 | Immediate field of the current instruction |
| imem_rdata | input | 32 | Word read from instruction memory at `pc` |
| pc | output | 32 | Current PC, the instruction-memory address |
| instr | output | 32 | Fetched instruction, passed through |

## Verification
The bench builds two copies of the block, both with the default 32-bit address, 16-bit immediate and 4-byte step. One copy uses the chained target adder and the other uses the parallel one, and every check is applied to both. Running both copies shows that the two adder variants give the same addresses on taken branches, including the largest positive and negative offsets. Because the width is 32 bits, wrap-around is easy to reach: a backward branch from address 0 lands at 0xFFFFFFFC.

// File: rtl/nfu_pkg.sv
package nfu_pkg;
   typedef enum logic {
      NPC_SEQ    = 1'b0,
      NPC_BRANCH = 1'b1
   } npc_mode_e;
endpackage

// File: rtl/nfu_adder.sv
module nfu_adder #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   // carry out dropped on purpose: address space wraps
   assign sum = a + b;
endmodule

// File: rtl/nfu_offset.sv
module nfu_offset #(
   parameter int IMM_W  = 16,
   parameter int ADDR_W = 32,
   parameter int ALIGN  = 2
) (
   input  logic [IMM_W-1:0]  imm,
   output logic [ADDR_W-1:0] off
);
   localparam int EXT_W = ADDR_W - IMM_W;

   logic [ADDR_W-1:0] sx;

   assign sx  = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign off = sx << ALIGN;
endmodule

// File: rtl/nfu_pc_reg.sv
module nfu_pc_reg #(
   parameter int               ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= RESET_PC;
      else     q <= d;
   end
endmodule

// File: rtl/fetch_next_pc.sv
module fetch_next_pc #(
   parameter int ADDR_W       = 32,
   parameter int IMM_W        = 16,
   parameter int INSTR_W      = 32,
   parameter int STEP         = 4,
   parameter int TARGET_CHAIN = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               br_sel,
   input  logic               alu_zero,
   input  logic [IMM_W-1:0]   imm,
   input  logic [INSTR_W-1:0] imem_rdata,
   output logic [ADDR_W-1:0]  pc,
   output logic [INSTR_W-1:0] instr
);
   import nfu_pkg::*;

   localparam int                ALIGN  = $clog2(STEP);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   // elaboration-time parameter checks
   if (STEP < 2 || (1 << ALIGN) != STEP) begin : g_bad_step
      $error("fetch_next_pc: STEP must be a power of two of at least 2");
   end
   if (IMM_W + ALIGN >= ADDR_W) begin : g_bad_imm
      $error("fetch_next_pc: shifted immediate must be narrower than ADDR_W");
   end
   if (TARGET_CHAIN != 0 && TARGET_CHAIN != 1) begin : g_bad_var
      $error("fetch_next_pc: TARGET_CHAIN must be 0 or 1");
   end

   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] br_off;
   logic [ADDR_W-1:0] br_target;
   logic [ADDR_W-1:0] pc_next;
   npc_mode_e         mode;

   nfu_adder #(.W(ADDR_W)) u_inc (
      .a   (pc),
      .b   (STEP_V),
      .sum (pc_inc)
   );

   nfu_offset #(.IMM_W(IMM_W), .ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_off (
      .imm (imm),
      .off (br_off)
   );

   if (TARGET_CHAIN == 1) begin : g_chain
      // offset added after the increment: two adders in series
      nfu_adder #(.W(ADDR_W)) u_tgt (
         .a   (pc_inc),
         .b   (br_off),
         .sum (br_target)
      );
   end else begin : g_parallel
      // step folded into the offset, which does not wait on the PC
      logic [ADDR_W-1:0] off_step;
      nfu_adder #(.W(ADDR_W)) u_fold (
         .a   (br_off),
         .b   (STEP_V),
         .sum (off_step)
      );
      nfu_adder #(.W(ADDR_W)) u_tgt (
         .a   (pc),
         .b   (off_step),
         .sum (br_target)
      );
   end

   assign mode    = (br_sel && alu_zero) ? NPC_BRANCH : NPC_SEQ;
   assign pc_next = (mode == NPC_BRANCH) ? br_target : pc_inc;

   nfu_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC('0)) u_pc (
      .clk (clk),
      .rst (rst),
      .d   (pc_next),
      .q   (pc)
   );

   assign instr = imem_rdata;
endmodule

// File: rtl/nfu_chk.sv
module nfu_chk #(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16,
   parameter int STEP   = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              br_sel,
   input logic              alu_zero,
   input logic [IMM_W-1:0]  imm,
   input logic [ADDR_W-1:0] pc
);
   localparam int                ALIGN  = $clog2(STEP);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   logic              armed = 1'b0;
   logic [ADDR_W-1:0] off_now;

   always_ff @(posedge clk) begin
      if (rst) armed <= 1'b1;
   end

   assign off_now = ADDR_W'($signed(imm)) << ALIGN;

   assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(rst)) |-> (pc == '0));

   assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(rst) && !$past(br_sel)) |-> (pc == $past(pc) + STEP_V));

   assert_taken_R4: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(rst) && $past(br_sel) && $past(alu_zero))
         |-> (pc == $past(pc) + STEP_V + $past(off_now)));

   assert_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(rst) && $past(br_sel) && !$past(alu_zero))
         |-> (pc == $past(pc) + STEP_V));

   assert_aligned_R8: assert property (@(posedge clk) disable iff (rst)
      armed |-> (pc[ALIGN-1:0] == '0));
endmodule

bind fetch_next_pc nfu_chk #(
   .ADDR_W (ADDR_W),
   .IMM_W  (IMM_W),
   .STEP   (STEP)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .br_sel   (br_sel),
   .alu_zero (alu_zero),
   .imm      (imm),
   .pc       (pc)
);

// File: tb/fetch_next_pc_tb.sv
module fetch_next_pc_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        br_sel;
   logic        alu_zero;
   logic [15:0] imm;
   logic [31:0] imem_rdata;
   logic [31:0] pc_a, pc_b, instr_a, instr_b;
   int          errs   = 0;
   int          checks = 0;
   logic [31:0] exp_pc;

   always #5 clk = ~clk;

   fetch_next_pc #(.TARGET_CHAIN(1)) u_dut (
      .clk (clk), .rst (rst), .br_sel (br_sel), .alu_zero (alu_zero),
      .imm (imm), .imem_rdata (imem_rdata), .pc (pc_a), .instr (instr_a));

   fetch_next_pc #(.TARGET_CHAIN(0)) u_alt (
      .clk (clk), .rst (rst), .br_sel (br_sel), .alu_zero (alu_zero),
      .imm (imm), .imem_rdata (imem_rdata), .pc (pc_b), .instr (instr_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_pc(input string req);
      chk({req, " chained"}, pc_a, exp_pc);
      chk({req, " parallel"}, pc_b, exp_pc);
      chk("R8 alignment", {30'd0, pc_a[1:0] | pc_b[1:0]}, 32'd0);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] boff(input logic [15:0] v);
      return {{14{v[15]}}, v, 2'b00};
   endfunction

   task automatic do_reset();
      rst = 1'b1; br_sel = 1'b1; alu_zero = 1'b1; imm = 16'h0010;
      tick();
      exp_pc = 32'd0;
      chk_pc("R1 reset");
      rst = 1'b0;
   endtask

   task automatic t_pass_through();
      imem_rdata = 32'hDEAD_BEEF; #1;
      chk("R2 instr chained", instr_a, 32'hDEAD_BEEF);
      chk("R2 instr parallel", instr_b, 32'hDEAD_BEEF);
      imem_rdata = 32'h0123_4567; #1;
      chk("R2 instr follows", instr_a, 32'h0123_4567);
      chk("R2 pc is fetch address", pc_a, exp_pc);
   endtask

   task automatic t_sequential();
      br_sel = 1'b0; alu_zero = 1'b0;
      for (int i = 0; i < 4; i++) begin
         imm = 16'h8000 ^ 16'(i * 37);
         tick();
         exp_pc = exp_pc + 32'd4;
         chk_pc("R3 sequential");
      end
   endtask

   task automatic t_zero_ignored();
      br_sel = 1'b0; alu_zero = 1'b1; imm = 16'h0100;
      tick();
      exp_pc = exp_pc + 32'd4;
      chk_pc("R9 zero without select");
   endtask

   task automatic t_taken();
      br_sel = 1'b1; alu_zero = 1'b1; imm = 16'd5;
      tick();
      exp_pc = exp_pc + 32'd4 + 32'd20;
      chk_pc("R4 taken +5");
      imm = 16'h7FFF;
      tick();
      exp_pc = exp_pc + 32'd4 + boff(16'h7FFF);
      chk_pc("R4 taken max positive");
   endtask

   task automatic t_not_taken();
      br_sel = 1'b1; alu_zero = 1'b0; imm = 16'd100;
      tick();
      exp_pc = exp_pc + 32'd4;
      chk_pc("R5 not taken");
   endtask

   task automatic t_negative();
      br_sel = 1'b1; alu_zero = 1'b1; imm = 16'hFFFF;
      tick();
      chk_pc("R6 minus one holds");
      imm = 16'hFFFD;
      tick();
      exp_pc = exp_pc - 32'd8;
      chk_pc("R6 minus three");
      imm = 16'h8000;
      tick();
      exp_pc = exp_pc + 32'd4 - 32'd131072;
      chk_pc("R6 most negative");
   endtask

   task automatic t_wrap();
      do_reset();
      br_sel = 1'b1; alu_zero = 1'b1; imm = 16'hFFFE;
      tick();
      exp_pc = 32'hFFFF_FFFC;
      chk_pc("R7 branch below zero");
      br_sel = 1'b0;
      tick();
      exp_pc = 32'd0;
      chk_pc("R7 increment wraps");
   endtask

   task automatic t_mid_reset();
      br_sel = 1'b0; alu_zero = 1'b0;
      tick(); tick();
      exp_pc = exp_pc + 32'd8;
      chk_pc("R3 before reset");
      do_reset();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; br_sel = 1'b0; alu_zero = 1'b0; imm = '0; imem_rdata = '0;
      exp_pc = '0;
      #2;
      do_reset();
      t_pass_through();
      t_sequential();
      t_zero_ignored();
      t_taken();
      t_not_taken();
      t_negative();
      t_wrap();
      t_mid_reset();
      finish_run();
   end
endmodule